// File: doc/BRIEF.md
# Clock Output Gate with Return-Clock Auto Detection

This block drives a clock output, CLK0, from a free-running internal oscillator and decides when that output is held still. Software can park it through a register write. It can also follow a return clock, CLKIN, that the clocked device sends back. The oscillator never stops. Only the output is gated, and the gate changes only while the oscillator sits at the level the output is being parked at. This keeps runt pulses off the pin.

After reset the block is in register mode. Software parks CLK0 high by writing a zero to the enable bit. The write is accepted only while an interrupt source is armed, and an interrupt event brings the clock back. The first toggle seen on CLKIN while CLK0 is running moves the block into auto-detect mode, and only a reset leaves that mode. In auto-detect mode the output is parked once CLKIN has been quiet for a few oscillator cycles. It parks at whatever level CLKIN is resting at, and one edge on CLKIN restarts it. CLKIN and SCL are sampled through two-flop synchronizers. CLKIN activity is taken from a pair of toggle flops clocked on each of its edges, so a return clock at the oscillator rate is still seen whatever its phase.

Top module: `clkout_gate`

## Requirements
- R1: After reset CLK0 follows the oscillator: high in each oscillator high phase and low in each low phase.
- R2: The block enters auto-detect mode on the first CLKIN edge seen while CLK0 runs in register mode with no stop pending. Only reset returns it to register mode, so a quiet CLKIN after reset never parks CLK0.
- R3: In auto-detect mode CLK0 is parked once no CLKIN edge has been observed for MISS_CYCLES oscillator cycles, plus the synchronizer latency. It keeps running for at least one cycle after CLKIN goes quiet.
- R4: In auto-detect mode CLK0 parks at the level CLKIN holds: parked low if CLKIN rests low, parked high if CLKIN rests high.
- R5: In auto-detect mode a single CLKIN transition restarts a parked CLK0, with a first rising edge within 8 oscillator cycles.
- R6: In register mode a last-bit write strobe carrying enable bit 0 is ignored while the interrupt-armed input is 0.
- R7: In register mode an accepted disabling write parks CLK0 on the SCL_PERIODS-th synchronized SCL falling edge after the strobe, or after OSC_STOP_LIMIT oscillator cycles, whichever comes first.
- R8: In register mode CLK0 is always parked high.
- R9: In register mode an interrupt event restarts a parked CLK0 and cancels a pending stop.
- R10: In auto-detect mode disabling register writes have no effect.
- R11: CLK0 never shows a high or low phase shorter than half an oscillator period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Free-running oscillator clock |
| rst_i | input | 1 | Synchronous active-high reset |
| clkin_i | input | 1 | Return clock from the clocked device (asynchronous) |
| scl_i | input | 1 | Serial bus clock line (asynchronous) |
| wr_last_bit_i | input | 1 | One-cycle strobe: last data bit of an enable write clocked in |
| wr_enable_bit_i | input | 1 | Enable bit value carried by that write |
| irq_armed_i | input | 1 | At least one interrupt source is programmed |
| irq_event_i | input | 1 | One-cycle interrupt event |
| clk0_o | output | 1 | Gated clock output |

## Verification
The bench keeps MISS_CYCLES and SCL_PERIODS at 4 and lowers OSC_STOP_LIMIT to 64. With that limit both stop paths of R7 can be reached in one run: a fast SCL parks the clock on its fourth falling edge well before the cycle cap, and an idle SCL parks it on the cap itself. CLKIN is modelled as CLK0 fed back with a 1 ns delay, which is the same-frequency, arbitrary-phase case that the toggle-flop detection has to handle.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    typedef enum logic [1:0] {
        GS_RUN  = 2'd0,
        GS_PEND = 2'd1,
        GS_STOP = 2'd2
    } gate_state_e;

    typedef struct packed {
        logic run;
        logic level;
    } gate_cmd_t;

    typedef struct packed {
        logic lvl;
        logic tog_r;
        logic tog_f;
        logic scl;
    } obs_t;

    localparam int SYNC_STAGES = 2;

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) stage_q[s] <= '0;
                    else       stage_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) stage_q[s] <= '0;
                    else       stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/clkgate_monitor.sv
module clkgate_monitor
    import clkgate_pkg::*;
#(
    parameter int MISS_CYCLES = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clkin_i,
    input  logic scl_i,
    input  logic count_en_i,
    output logic act_o,
    output logic miss_o,
    output logic lvl_o,
    output logic scl_fall_o
);
    localparam int GAP_LIMIT = MISS_CYCLES + SYNC_STAGES + 1;
    localparam int GW        = cnt_width(GAP_LIMIT);
    localparam logic [GW-1:0] GAP_TOP = GW'(GAP_LIMIT);

    // Toggle flops in the return-clock domain: one per CLKIN edge direction
    logic tog_r_q, tog_f_q;

    always_ff @(posedge clkin_i or posedge rst_i) begin
        if (rst_i) tog_r_q <= 1'b0;
        else       tog_r_q <= ~tog_r_q;
    end

    always_ff @(negedge clkin_i or posedge rst_i) begin
        if (rst_i) tog_f_q <= 1'b0;
        else       tog_f_q <= ~tog_f_q;
    end

    obs_t raw, obs_s;
    logic [2:0] prev_q;   // {tog_r, tog_f, scl} one cycle back

    assign raw = '{lvl: clkin_i, tog_r: tog_r_q, tog_f: tog_f_q, scl: scl_i};

    clkgate_sync #(.WIDTH($bits(obs_t)), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (raw),
        .q_o   (obs_s)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= '0;
        else       prev_q <= {obs_s.tog_r, obs_s.tog_f, obs_s.scl};
    end

    assign act_o      = (obs_s.tog_r ^ prev_q[2]) | (obs_s.tog_f ^ prev_q[1]);
    assign scl_fall_o = prev_q[0] & ~obs_s.scl;
    assign lvl_o      = obs_s.lvl;

    // Oscillator cycles since the last observed CLKIN edge, counted while running
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || act_o || !count_en_i) gap_q <= '0;
        else if (gap_q != GAP_TOP)         gap_q <= gap_q + 1'b1;
    end

    assign miss_o = (gap_q == GAP_TOP);
endmodule

// File: rtl/clkgate_stop_timer.sv
module clkgate_stop_timer
    import clkgate_pkg::*;
#(
    parameter int SCL_PERIODS    = 4,
    parameter int OSC_STOP_LIMIT = 1024
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clear_i,
    input  logic scl_fall_i,
    output logic expire_o
);
    localparam int SW = cnt_width(SCL_PERIODS);
    localparam int OW = cnt_width(OSC_STOP_LIMIT);
    localparam logic [SW-1:0] SCL_LAST = SW'(SCL_PERIODS - 1);
    localparam logic [OW-1:0] OSC_LAST = OW'(OSC_STOP_LIMIT - 1);

    logic [SW-1:0] scl_cnt_q;
    logic [OW-1:0] osc_cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            scl_cnt_q <= '0;
            osc_cnt_q <= '0;
        end else begin
            if (osc_cnt_q != OSC_LAST) osc_cnt_q <= osc_cnt_q + 1'b1;
            if (scl_fall_i && scl_cnt_q != SCL_LAST) scl_cnt_q <= scl_cnt_q + 1'b1;
        end
    end

    assign expire_o = !clear_i &&
                      ((osc_cnt_q == OSC_LAST) || (scl_fall_i && scl_cnt_q == SCL_LAST));
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
    import clkgate_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        act_i,
    input  logic        miss_i,
    input  logic        lvl_i,
    input  logic        wr_strobe_i,
    input  logic        en_bit_i,
    input  logic        irq_armed_i,
    input  logic        irq_event_i,
    input  logic        expire_i,
    output gate_state_e state_o,
    output logic        auto_o,
    output gate_cmd_t   cmd_o
);
    gate_state_e st_q, st_n;
    logic        auto_q, auto_n;
    logic        lvl_q, lvl_n;

    always_comb begin
        st_n   = st_q;
        auto_n = auto_q;
        lvl_n  = lvl_q;
        unique case (st_q)
            GS_RUN: begin
                if (auto_q) begin
                    if (miss_i) begin
                        st_n  = GS_STOP;
                        lvl_n = lvl_i;
                    end
                end else if (act_i) begin
                    auto_n = 1'b1;
                end else if (wr_strobe_i && !en_bit_i && irq_armed_i) begin
                    st_n = GS_PEND;
                end
            end
            GS_PEND: begin
                if (irq_event_i) begin
                    st_n = GS_RUN;
                end else if (expire_i) begin
                    st_n  = GS_STOP;
                    lvl_n = 1'b1;
                end
            end
            GS_STOP: begin
                if (auto_q ? act_i : irq_event_i) st_n = GS_RUN;
            end
            default: st_n = GS_RUN;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q   <= GS_RUN;
            auto_q <= 1'b0;
            lvl_q  <= 1'b1;
        end else begin
            st_q   <= st_n;
            auto_q <= auto_n;
            lvl_q  <= lvl_n;
        end
    end

    assign state_o   = st_q;
    assign auto_o    = auto_q;
    assign cmd_o.run   = (st_q != GS_STOP);
    assign cmd_o.level = lvl_q;
endmodule

// File: rtl/clkgate_cell.sv
module clkgate_cell
    import clkgate_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  gate_cmd_t cmd_i,
    output logic      clk0_o,
    output logic      stop_hi_o,
    output logic      stop_lo_o
);
    // Park-high changes only at the rising edge (oscillator high),
    // park-low only at the falling edge (oscillator low).
    always_ff @(posedge clk_i) begin
        if (rst_i) stop_hi_o <= 1'b0;
        else       stop_hi_o <= ~cmd_i.run & cmd_i.level;
    end

    always_ff @(negedge clk_i) begin
        if (rst_i) stop_lo_o <= 1'b0;
        else       stop_lo_o <= ~cmd_i.run & ~cmd_i.level;
    end

    assign clk0_o = (clk_i & ~stop_lo_o) | stop_hi_o;
endmodule

// File: rtl/clkout_gate.sv
module clkout_gate
    import clkgate_pkg::*;
#(
    parameter int MISS_CYCLES    = 4,
    parameter int SCL_PERIODS    = 4,
    parameter int OSC_STOP_LIMIT = 1024
) (
    input  logic osc_clk_i,
    input  logic rst_i,
    input  logic clkin_i,
    input  logic scl_i,
    input  logic wr_last_bit_i,
    input  logic wr_enable_bit_i,
    input  logic irq_armed_i,
    input  logic irq_event_i,
    output logic clk0_o
);
    gate_state_e state;
    gate_cmd_t   cmd;
    logic        auto_mode, act, miss, lvl, scl_fall, expire;
    logic        stop_hi, stop_lo;

    clkgate_monitor #(.MISS_CYCLES(MISS_CYCLES)) u_mon (
        .clk_i      (osc_clk_i),
        .rst_i      (rst_i),
        .clkin_i    (clkin_i),
        .scl_i      (scl_i),
        .count_en_i (auto_mode && state == GS_RUN),
        .act_o      (act),
        .miss_o     (miss),
        .lvl_o      (lvl),
        .scl_fall_o (scl_fall)
    );

    clkgate_stop_timer #(
        .SCL_PERIODS    (SCL_PERIODS),
        .OSC_STOP_LIMIT (OSC_STOP_LIMIT)
    ) u_timer (
        .clk_i      (osc_clk_i),
        .rst_i      (rst_i),
        .clear_i    (state != GS_PEND),
        .scl_fall_i (scl_fall),
        .expire_o   (expire)
    );

    clkgate_ctrl u_ctrl (
        .clk_i       (osc_clk_i),
        .rst_i       (rst_i),
        .act_i       (act),
        .miss_i      (miss),
        .lvl_i       (lvl),
        .wr_strobe_i (wr_last_bit_i),
        .en_bit_i    (wr_enable_bit_i),
        .irq_armed_i (irq_armed_i),
        .irq_event_i (irq_event_i),
        .expire_i    (expire),
        .state_o     (state),
        .auto_o      (auto_mode),
        .cmd_o       (cmd)
    );

    clkgate_cell u_cell (
        .clk_i     (osc_clk_i),
        .rst_i     (rst_i),
        .cmd_i     (cmd),
        .clk0_o    (clk0_o),
        .stop_hi_o (stop_hi),
        .stop_lo_o (stop_lo)
    );
endmodule

// File: rtl/clkout_gate_chk.sv
module clkout_gate_chk
    import clkgate_pkg::*;
(
    input logic        clk_i,
    input logic        rst_i,
    input gate_state_e state_i,
    input logic        auto_i,
    input logic        level_i,
    input logic        act_i,
    input logic        strobe_i,
    input logic        en_bit_i,
    input logic        armed_i,
    input logic        irq_i,
    input logic        stop_hi_i,
    input logic        stop_lo_i
);
    // R2: auto-detect mode is entered only from a running register-mode clock on an edge
    a_r2_entry_on_activity: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(auto_i) |-> ($past(act_i) && $past(state_i) == GS_RUN));

    // R2: once entered, auto-detect mode persists until reset
    a_r2_auto_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        auto_i |=> auto_i);

    // R5: an edge on CLKIN wakes a parked clock in auto-detect mode
    a_r5_edge_restarts: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == GS_STOP && auto_i && act_i) |=> state_i == GS_RUN);

    // R6: unarmed disabling write leaves the clock running
    a_r6_unarmed_ignored: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == GS_RUN && !auto_i && strobe_i && !en_bit_i && !armed_i) |=> state_i == GS_RUN);

    // R8: register-mode parking is always at the high level
    a_r8_park_high: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == GS_STOP && !auto_i) |-> level_i);

    // R9: interrupt restarts a parked clock in register mode
    a_r9_irq_restarts: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == GS_STOP && !auto_i && irq_i) |=> state_i == GS_RUN);

    // R10: no stop is scheduled from a register write in auto-detect mode
    a_r10_no_pend_in_auto: assert property (@(posedge clk_i) disable iff (rst_i)
        (auto_i && state_i == GS_RUN) |=> state_i != GS_PEND);

    // R11: the two park paths never hold the output at the same time
    a_r11_single_park: assert property (@(posedge clk_i) disable iff (rst_i)
        !(stop_hi_i && stop_lo_i));
endmodule

bind clkout_gate clkout_gate_chk chk_i (
    .clk_i     (osc_clk_i),
    .rst_i     (rst_i),
    .state_i   (state),
    .auto_i    (auto_mode),
    .level_i   (cmd.level),
    .act_i     (act),
    .strobe_i  (wr_last_bit_i),
    .en_bit_i  (wr_enable_bit_i),
    .armed_i   (irq_armed_i),
    .irq_i     (irq_event_i),
    .stop_hi_i (stop_hi),
    .stop_lo_i (stop_lo)
);

// File: tb/clkout_gate_tb_top.sv
`timescale 1ns/1ps
module clkout_gate_tb_top;

    localparam int RUN_C  = 0;
    localparam int HIGH_C = 1;
    localparam int LOW_C  = 2;

    logic osc_clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic strobe = 1'b0;
    logic en_bit = 1'b1;
    logic armed = 1'b0;
    logic irq = 1'b0;
    logic mcu_run = 1'b0;
    logic clkin_hold = 1'b0;
    logic clk0;
    logic clk0_dly;
    logic clkin;

    int n_chk = 0;
    int n_fail = 0;
    int rise_cnt = 0;
    int short_cnt = 0;
    bit finished = 1'b0;

    always #2 osc_clk = ~osc_clk;   // 250 MHz

    assign #1 clk0_dly = clk0;
    assign clkin = mcu_run ? clk0_dly : clkin_hold;

    clkout_gate #(
        .MISS_CYCLES    (4),
        .SCL_PERIODS    (4),
        .OSC_STOP_LIMIT (64)
    ) dut_i (
        .osc_clk_i       (osc_clk),
        .rst_i           (rst),
        .clkin_i         (clkin),
        .scl_i           (scl),
        .wr_last_bit_i   (strobe),
        .wr_enable_bit_i (en_bit),
        .irq_armed_i     (armed),
        .irq_event_i     (irq),
        .clk0_o          (clk0)
    );

    // Pulse-width monitor for R11
    realtime t_last = 0.0;
    bit seen_edge = 1'b0;
    always @(clk0) begin
        if (seen_edge && ($realtime - t_last) < 1.9) short_cnt++;
        seen_edge = 1'b1;
        t_last = $realtime;
        if (clk0 === 1'b1) rise_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge osc_clk);
    endtask

    // Classify CLK0 over n oscillator cycles: RUN, HIGH, LOW or 3 (mixed)
    task automatic observe(input int n, output int code);
        bit all_hi = 1'b1, all_lo = 1'b1, is_run = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(posedge osc_clk); #1;
            if (clk0 !== 1'b1) begin all_hi = 1'b0; is_run = 1'b0; end
            if (clk0 !== 1'b0) all_lo = 1'b0;
            @(negedge osc_clk); #1;
            if (clk0 !== 1'b0) begin all_lo = 1'b0; is_run = 1'b0; end
            if (clk0 !== 1'b1) all_hi = 1'b0;
        end
        code = is_run ? RUN_C : all_hi ? HIGH_C : all_lo ? LOW_C : 3;
        @(negedge osc_clk);
    endtask

    task automatic pulse_strobe(input logic en, input logic arm);
        en_bit = en; armed = arm; strobe = 1'b1;
        cyc(1);
        strobe = 1'b0; en_bit = 1'b1;
    endtask

    task automatic pulse_irq();
        irq = 1'b1; cyc(1); irq = 1'b0;
    endtask

    task automatic scl_period();
        scl = 1'b0; cyc(3);
        scl = 1'b1; cyc(3);
    endtask

    task automatic t_reset();
        int c;
        rst = 1'b1; cyc(5); rst = 1'b0; cyc(2);
        observe(4, c);
        chk("R1 running after reset", c, RUN_C);
    endtask

    task automatic t_unarmed();
        int c;
        pulse_strobe(1'b0, 1'b0);
        cyc(80);
        observe(2, c);
        chk("R6 unarmed disable ignored", c, RUN_C);
    endtask

    task automatic t_scl_stop();
        int c;
        pulse_strobe(1'b0, 1'b1);
        for (int p = 0; p < 3; p++) scl_period();
        cyc(2);
        observe(2, c);
        chk("R7 running before fourth SCL fall", c, RUN_C);
        scl_period();
        cyc(4);
        observe(2, c);
        chk("R7/R8 parked high after fourth SCL fall", c, HIGH_C);
    endtask

    task automatic t_irq_restart();
        int c;
        pulse_irq();
        cyc(4);
        observe(3, c);
        chk("R9 interrupt restarts clock", c, RUN_C);
    endtask

    task automatic t_cap_stop();
        int c;
        pulse_strobe(1'b0, 1'b1);
        cyc(53);
        observe(2, c);
        chk("R7 running before cycle cap", c, RUN_C);
        cyc(13);
        observe(2, c);
        chk("R8 parked high on cycle cap", c, HIGH_C);
        pulse_irq();
        cyc(4);
        observe(2, c);
        chk("R9 restart after cap stop", c, RUN_C);
    endtask

    task automatic t_cancel();
        int c;
        pulse_strobe(1'b0, 1'b1);
        cyc(10);
        pulse_irq();
        cyc(80);
        observe(2, c);
        chk("R9 interrupt cancels pending stop", c, RUN_C);
    endtask

    task automatic t_auto_quiet_low();
        int c;
        mcu_run = 1'b1;
        cyc(20);
        observe(2, c);
        chk("R2 running with CLKIN following", c, RUN_C);
        clkin_hold = 1'b0; mcu_run = 1'b0;
        cyc(1);
        observe(1, c);
        chk("R3 still running just after CLKIN quiet", c, RUN_C);
        cyc(20);
        observe(3, c);
        chk("R3/R4 parked low with CLKIN low", c, LOW_C);
    endtask

    task automatic t_single_edge();
        int c, r0;
        r0 = rise_cnt;
        clkin_hold = 1'b1;
        cyc(8);
        chk("R5 single edge restarts within 8 cycles", int'(rise_cnt > r0), 1);
        cyc(20);
        observe(3, c);
        chk("R4 parked high with CLKIN high", c, HIGH_C);
    endtask

    task automatic t_auto_sw_write();
        int c;
        clkin_hold = 1'b0;
        cyc(1);
        mcu_run = 1'b1;
        cyc(30);
        observe(2, c);
        chk("R5 restarted and following again", c, RUN_C);
        pulse_strobe(1'b0, 1'b1);
        cyc(80);
        observe(2, c);
        chk("R10 register disable ignored in auto mode", c, RUN_C);
    endtask

    task automatic t_reset_mode();
        int c;
        mcu_run = 1'b0; clkin_hold = 1'b0; armed = 1'b0;
        cyc(2);
        rst = 1'b1; cyc(4); rst = 1'b0;
        cyc(40);
        observe(4, c);
        chk("R2 reset returns register mode, quiet CLKIN keeps clock", c, RUN_C);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        cyc(1);
        t_reset();
        t_unarmed();
        t_scl_stop();
        t_irq_restart();
        t_cap_stop();
        t_cancel();
        t_auto_quiet_low();
        t_single_edge();
        t_auto_sw_write();
        t_reset_mode();
        chk("R11 no short CLK0 phase", short_cnt, 0);
        finish_run();
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule